// File: doc/BRIEF.md
# Bit-Addressable SRAM Bridge

This bridge connects a simple 32-bit request/ready bus master to a word-wide synchronous SRAM. It serves two address windows. In the direct window, reads and writes reach the memory unchanged, with byte, half-word or word sizing. In the alias window, each 32-bit word stands for one bit of the SRAM. Reading an alias word returns that bit as 0 or 1. Writing an alias word sets or clears that bit alone.

An alias write is done inside the bridge as one memory read followed by one write-back to a single byte lane. The master sees no ready until the write-back has been issued, so no other access can come between the read and the write. Addresses that fall in neither window get an error response at once and cause no memory traffic.

Top module: `bitband_bridge`

## Requirements
- R1: Addresses from `SRAM_BASE` up to `SRAM_BASE+SRAM_BYTES-1` are direct accesses. A direct write drives byte enables in little-endian order. Size code 0 (byte) enables lane `addr[1:0]` and places `wdata[7:0]` there. Size code 1 (half-word) enables lanes `{addr[1],0}` and `{addr[1],1}` with `wdata[15:0]`, and ignores `addr[0]`. Size code 2 (word) enables all four lanes with `wdata`, and ignores `addr[1:0]`.
- R2: A direct read returns the addressed byte or half-word zero-extended into the low bits of `rdata`, or the whole word for size code 2.
- R3: For an address in the alias window, take the offset `off = addr - ALIAS_BASE`, where `off < 32*SRAM_BYTES`. The target byte is `off >> 5` and the bit index is `off[4:2]`. Bits `off[1:0]` and the size code are ignored.
- R4: An alias read returns `32'h0000_0001` or `32'h0000_0000`, equal to the current value of the addressed bit.
- R5: An alias write changes only the addressed bit, to `wdata[0]`. Bits 31:1 of `wdata` are ignored, and all other memory bits keep their values.
- R6: An alias write issues exactly one SRAM read and then exactly one SRAM write with a single byte lane enabled. `ready` stays low from acceptance until the response, which comes 3 clock edges after the accepting edge, and no other request is accepted in between.
- R7: An address in neither window, or a direct access with size code 3, gets `resp_valid` and `resp_err` high together with `rdata` equal to zero. This happens on the accepting edge and lasts one cycle. Such an access issues no SRAM command.
- R8: The response to a direct write comes 1 edge after acceptance. The response to a direct or alias read comes 2 edges after acceptance. `resp_err` is low for all of these.
- R9: After reset, `ready` is high, and `resp_valid`, `resp_err` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid; accepted on an edge where `ready` is high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Byte address |
| size | input | 2 | 0 byte, 1 half-word, 2 word, 3 invalid |
| wdata | input | 32 | Write data, LSB-aligned |
| ready | output | 1 | Bridge can accept a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_err | output | 1 | Response is an error |
| rdata | output | 32 | Read data (zero for writes and errors) |
| mem_en | output | 1 | SRAM command enable |
| mem_we | output | 1 | SRAM write enable |
| mem_be | output | 4 | SRAM byte-lane enables |
| mem_addr | output | AW | SRAM word address |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, valid one cycle after the command |

## Verification
An alias write's read-modify-write can coincide with a new master request. To provoke this, the bench keeps `req` high through the write and switches it straight to a read of the same alias word. It then checks three things: `ready` stays low for exactly three edges, the SRAM sees exactly one read and one write in that time, and the following read returns the freshly written bit. Error responses are also issued in the accepting cycle, right after memory traffic has ended. The bench judges that no SRAM command accompanies them and that the strobe drops on the next cycle.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DWR   = 3'd1,
    ST_RWAIT = 3'd2,
    ST_RTAKE = 3'd3,
    ST_WB    = 3'd4
  } bb_state_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } bb_size_t;

  typedef enum logic [1:0] {
    RG_NONE  = 2'd0,
    RG_SRAM  = 2'd1,
    RG_ALIAS = 2'd2
  } bb_region_t;
endpackage

// File: rtl/bb_decode.sv
module bb_decode import bb_pkg::*; #(
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter int          SRAM_BYTES = 98304,
  localparam int         OW         = $clog2(SRAM_BYTES)
) (
  input  logic [31:0]   addr,
  output bb_region_t    region,
  output logic [OW-1:0] byte_off,
  output logic [2:0]    bit_idx
);
  localparam logic [31:0] SPAN  = 32'(SRAM_BYTES);
  localparam logic [31:0] ASPAN = 32'(SRAM_BYTES) << 5;

  logic [31:0] s_off;
  logic [31:0] a_off;
  logic        in_sram;
  logic        in_alias;

  always_comb begin
    s_off    = addr - SRAM_BASE;
    a_off    = addr - ALIAS_BASE;
    in_sram  = (addr >= SRAM_BASE) && (s_off < SPAN);
    in_alias = (addr >= ALIAS_BASE) && (a_off < ASPAN);
    if (in_sram)       region = RG_SRAM;
    else if (in_alias) region = RG_ALIAS;
    else               region = RG_NONE;
    byte_off = in_alias ? a_off[OW+4:5] : s_off[OW-1:0];
    bit_idx  = a_off[4:2];
  end
endmodule

// File: rtl/bb_wsteer.sv
module bb_wsteer import bb_pkg::*; (
  input  bb_size_t    size,
  input  logic [1:0]  lane,
  input  logic [31:0] wdata,
  output logic [3:0]  be,
  output logic [31:0] lanes
);
  for (genvar g = 0; g < 4; g++) begin : g_lane
    localparam logic [1:0] LN = 2'(g);
    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          be[g]          = (lane == LN);
          lanes[8*g +: 8] = wdata[7:0];
        end
        SZ_HALF: begin
          be[g]          = (lane[1] == LN[1]);
          lanes[8*g +: 8] = LN[0] ? wdata[15:8] : wdata[7:0];
        end
        default: begin
          be[g]          = 1'b1;
          lanes[8*g +: 8] = wdata[8*g +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/bb_rextract.sv
module bb_rextract import bb_pkg::*; (
  input  logic [31:0] word,
  input  bb_size_t    size,
  input  logic [1:0]  lane,
  input  logic [2:0]  bit_idx,
  input  logic        is_alias,
  output logic [31:0] rd
);
  logic [1:0]  sh;
  logic [31:0] shifted;

  always_comb begin
    unique case (size)
      SZ_BYTE: sh = lane;
      SZ_HALF: sh = {lane[1], 1'b0};
      default: sh = 2'd0;
    endcase
    shifted = word >> {sh, 3'b000};
    if (is_alias)
      rd = {31'd0, word[{lane, bit_idx}]};
    else begin
      unique case (size)
        SZ_BYTE: rd = {24'd0, shifted[7:0]};
        SZ_HALF: rd = {16'd0, shifted[15:0]};
        default: rd = shifted;
      endcase
    end
  end
endmodule

// File: rtl/bb_bitmerge.sv
module bb_bitmerge (
  input  logic [31:0] old_word,
  input  logic [1:0]  lane,
  input  logic [2:0]  bit_idx,
  input  logic        new_bit,
  output logic [31:0] new_word,
  output logic [3:0]  be
);
  for (genvar i = 0; i < 32; i++) begin : g_bit
    localparam logic [4:0] POS = 5'(i);
    assign new_word[i] = (POS == {lane, bit_idx}) ? new_bit : old_word[i];
  end
  for (genvar g = 0; g < 4; g++) begin : g_be
    assign be[g] = (lane == 2'(g));
  end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge import bb_pkg::*; #(
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter int          SRAM_BYTES = 98304,
  localparam int         OW         = $clog2(SRAM_BYTES),
  localparam int         AW         = OW - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          we,
  input  logic [31:0]   addr,
  input  logic [1:0]    size,
  input  logic [31:0]   wdata,
  output logic          ready,
  output logic          resp_valid,
  output logic          resp_err,
  output logic [31:0]   rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [3:0]    mem_be,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  bb_state_t     state;
  bb_region_t    dec_region;
  logic [OW-1:0] dec_off;
  logic [2:0]    dec_bit;
  bb_size_t      in_size;
  logic [3:0]    st_be;
  logic [31:0]   st_lanes;
  logic [31:0]   rx_data;
  logic [31:0]   mg_word;
  logic [3:0]    mg_be;
  logic          bad_req;

  bb_size_t    lat_size;
  logic [1:0]  lat_lane;
  logic [2:0]  lat_bit;
  logic        lat_alias;
  logic        lat_we;
  logic        lat_wbit;

  assign in_size = bb_size_t'(size);
  assign ready   = (state == ST_IDLE);
  assign bad_req = (dec_region == RG_NONE) ||
                   ((dec_region == RG_SRAM) && (in_size == SZ_BAD));

  bb_decode #(.SRAM_BASE(SRAM_BASE), .ALIAS_BASE(ALIAS_BASE),
              .SRAM_BYTES(SRAM_BYTES)) u_dec (
    .addr(addr), .region(dec_region), .byte_off(dec_off), .bit_idx(dec_bit)
  );

  bb_wsteer u_ws (
    .size(in_size), .lane(dec_off[1:0]), .wdata(wdata),
    .be(st_be), .lanes(st_lanes)
  );

  bb_rextract u_rx (
    .word(mem_rdata), .size(lat_size), .lane(lat_lane), .bit_idx(lat_bit),
    .is_alias(lat_alias), .rd(rx_data)
  );

  bb_bitmerge u_mg (
    .old_word(mem_rdata), .lane(lat_lane), .bit_idx(lat_bit),
    .new_bit(lat_wbit), .new_word(mg_word), .be(mg_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      rdata      <= '0;
      mem_en     <= 1'b0;
      mem_we     <= 1'b0;
      mem_be     <= '0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      lat_size   <= SZ_BYTE;
      lat_lane   <= '0;
      lat_bit    <= '0;
      lat_alias  <= 1'b0;
      lat_we     <= 1'b0;
      lat_wbit   <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          mem_en <= 1'b0;
          mem_we <= 1'b0;
          if (req) begin
            if (bad_req) begin
              resp_valid <= 1'b1;
              resp_err   <= 1'b1;
              rdata      <= '0;
            end else begin
              mem_en    <= 1'b1;
              mem_addr  <= dec_off[OW-1:2];
              lat_size  <= in_size;
              lat_lane  <= dec_off[1:0];
              lat_bit   <= dec_bit;
              lat_alias <= (dec_region == RG_ALIAS);
              lat_we    <= we;
              lat_wbit  <= wdata[0];
              if (we && dec_region == RG_SRAM) begin
                mem_we    <= 1'b1;
                mem_be    <= st_be;
                mem_wdata <= st_lanes;
                state     <= ST_DWR;
              end else begin
                mem_we <= 1'b0;
                state  <= ST_RWAIT;
              end
            end
          end
        end
        ST_DWR: begin
          mem_en     <= 1'b0;
          mem_we     <= 1'b0;
          resp_valid <= 1'b1;
          rdata      <= '0;
          state      <= ST_IDLE;
        end
        ST_RWAIT: begin
          mem_en <= 1'b0;
          state  <= ST_RTAKE;
        end
        ST_RTAKE: begin
          if (lat_alias && lat_we) begin
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_be    <= mg_be;
            mem_wdata <= mg_word;
            state     <= ST_WB;
          end else begin
            resp_valid <= 1'b1;
            rdata      <= rx_data;
            state      <= ST_IDLE;
          end
        end
        ST_WB: begin
          mem_en     <= 1'b0;
          mem_we     <= 1'b0;
          resp_valid <= 1'b1;
          rdata      <= '0;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r6_hold_off: assert property (@(posedge clk) disable iff (rst)
    (req && ready && we && dec_region == RG_ALIAS) |=> !ready);

  a_r6_single_lane: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we && state == ST_WB) |-> ($countones(mem_be) == 1));

  a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RTAKE && lat_alias && lat_we) |=> (state == ST_WB && mem_en));

  a_r7_err_quiet: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> (resp_valid && rdata == 32'd0 && !mem_en));

  a_r7_err_pulse: assert property (@(posedge clk) disable iff (rst)
    resp_err |=> !resp_err || $past(req && ready));

  a_r4_bit_only: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_err && $past(state == ST_RTAKE && lat_alias))
      |-> (rdata[31:1] == 31'd0));

  a_r8_write_ack: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DWR) |=> (resp_valid && ready && !mem_en));
endmodule

// File: tb/sim_bitband_bridge.sv
module sim_bitband_bridge;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] SBASE      = 32'h2000_0000;
  localparam logic [31:0] ABASE      = 32'h2200_0000;
  localparam int          NBYTES     = 64;
  localparam int          NWORDS     = NBYTES / 4;
  localparam int          AW         = $clog2(NBYTES) - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [1:0]  size = '0;
  logic ready, resp_valid, resp_err, mem_en, mem_we;
  logic [31:0] rdata, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  mem_be;
  logic [AW-1:0] mem_addr;

  logic [31:0] mem [NWORDS];
  logic [7:0]  rb  [NBYTES];
  int n_rd = 0, n_wr = 0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitband_bridge #(.SRAM_BASE(SBASE), .ALIAS_BASE(ABASE), .SRAM_BYTES(NBYTES)) u0 (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .size(size),
    .wdata(wdata), .ready(ready), .resp_valid(resp_valid), .resp_err(resp_err),
    .rdata(rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem[mem_addr][8*i +: 8] <= mem_wdata[8*i +: 8];
        n_wr <= n_wr + 1;
      end else n_rd <= n_rd + 1;
      mem_rdata <= mem[mem_addr];
    end
  end

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_word(input int w);
    return {rb[4*w+3], rb[4*w+2], rb[4*w+1], rb[4*w]};
  endfunction

  task automatic access(input logic w, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] d, output logic [31:0] rd,
                        output logic e, output int lat);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = sz; wdata = d;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    lat = 0;
    while (!resp_valid) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    rd = rdata; e = resp_err;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic e;
    int lat;
    int r0, w0;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R9", {31'd0, ready}, 32'd1, "ready after reset");
    check("R9", {29'd0, resp_valid, resp_err, mem_en}, 32'd0, "quiet after reset");

    // R1/R8: word writes fill memory
    for (int w = 0; w < NWORDS; w++) begin
      logic [31:0] p = 32'hA500_0000 ^ (w * 32'h0103_0507);
      access(1'b1, SBASE + 4*w, 2'd2, p, rd, e, lat);
      for (int i = 0; i < 4; i++) rb[4*w+i] = p[8*i +: 8];
      if (w == 0) begin
        check("R8", 32'(lat), 32'd1, "direct write latency");
        check("R8", {31'd0, e}, 32'd0, "direct write err");
      end
    end
    for (int w = 0; w < NWORDS; w++) begin
      access(1'b0, SBASE + 4*w + (w % 4), 2'd2, 32'd0, rd, e, lat);
      check("R2", rd, ref_word(w), "word read");
      if (w == 0) check("R8", 32'(lat), 32'd2, "direct read latency");
    end

    // R1: byte writes with junk upper data
    for (int b = 0; b < NBYTES; b++) begin
      logic [7:0] v = 8'((b * 37 + 11) & 255);
      access(1'b1, SBASE + b, 2'd0, {24'hDEADBE, v}, rd, e, lat);
      rb[b] = v;
    end
    for (int b = 0; b < NBYTES; b++) begin
      access(1'b0, SBASE + b, 2'd0, 32'd0, rd, e, lat);
      check("R2", rd, {24'd0, rb[b]}, "byte read");
    end
    // R1: half writes, odd addresses ignore addr[0]
    for (int h = 0; h < NBYTES/2; h++) begin
      logic [15:0] v = 16'(h * 16'h0911 + 16'h3C5A);
      access(1'b1, SBASE + 2*h + (h % 2), 2'd1, {16'hFFFF, v}, rd, e, lat);
      rb[2*h] = v[7:0]; rb[2*h+1] = v[15:8];
    end
    for (int h = 0; h < NBYTES/2; h++) begin
      access(1'b0, SBASE + 2*h + ((h+1) % 2), 2'd1, 32'd0, rd, e, lat);
      check("R2", rd, {16'd0, rb[2*h+1], rb[2*h]}, "half read");
    end
    for (int w = 0; w < NWORDS; w++) begin
      access(1'b0, SBASE + 4*w, 2'd2, 32'd0, rd, e, lat);
      check("R1", rd, ref_word(w), "lanes after half writes");
    end

    // R3/R4: exhaustive alias reads, low bits and size ignored
    for (int b = 0; b < NBYTES; b++)
      for (int k = 0; k < 8; k++) begin
        access(1'b0, ABASE + b*32 + k*4 + (k % 4), 2'(k % 4), 32'd0, rd, e, lat);
        check("R4", rd, {31'd0, rb[b][k]}, "alias read");
        if (b == 0 && k == 0) check("R8", 32'(lat), 32'd2, "alias read latency");
        if (k == 3) check("R3", {31'd0, e}, 32'd0, "alias size 3 no error");
      end

    // R5/R6: exhaustive alias writes
    for (int b = 0; b < NBYTES; b++)
      for (int k = 0; k < 8; k++) begin
        logic nb = ((b + k) % 3 == 0);
        r0 = n_rd; w0 = n_wr;
        access(1'b1, ABASE + b*32 + k*4, 2'd0,
               {31'h2AAA_AAAA ^ 31'(b*k + 1), nb}, rd, e, lat);
        rb[b][k] = nb;
        check("R6", 32'(lat), 32'd3, "alias write latency");
        check("R6", 32'((n_rd - r0) * 16 + (n_wr - w0)), 32'h11, "one read one write");
      end
    for (int w = 0; w < NWORDS; w++) begin
      access(1'b0, SBASE + 4*w, 2'd2, 32'd0, rd, e, lat);
      check("R5", rd, ref_word(w), "memory after alias writes");
    end

    // R6: request held high across alias write
    begin
      int busy = 0;
      int tgt = 13, kb = 5;
      logic nb = ~rb[tgt][kb];
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = ABASE + tgt*32 + kb*4; size = 2'd2;
      wdata = {31'h7FFF_FFFF, nb};
      @(posedge clk);
      r0 = n_rd; w0 = n_wr;
      @(negedge clk);
      we = 1'b0; wdata = 32'd0;
      while (!ready) begin busy++; @(negedge clk); end
      check("R6", 32'(busy), 32'd3, "ready low edges");
      check("R6", 32'((n_rd - r0) * 16 + (n_wr - w0)), 32'h11, "held-req traffic");
      @(posedge clk);
      @(negedge clk); req = 1'b0;
      while (!resp_valid) @(negedge clk);
      rb[tgt][kb] = nb;
      check("R6", rdata, {31'd0, nb}, "read after held write");
    end

    // R7: outside both windows and bad size
    begin
      logic [31:0] bad [7];
      bad[0] = SBASE - 1; bad[1] = SBASE + NBYTES; bad[2] = ABASE - 4;
      bad[3] = ABASE + NBYTES*32; bad[4] = 32'd0; bad[5] = 32'hFFFF_FFFC;
      bad[6] = SBASE + 8;
      for (int i = 0; i < 7; i++)
        for (int wr = 0; wr < 2; wr++) begin
          r0 = n_rd; w0 = n_wr;
          access(wr[0], bad[i], (i == 6) ? 2'd3 : 2'd2, 32'hFFFF_FFFF, rd, e, lat);
          check("R7", {31'd0, e}, 32'd1, "error flag");
          check("R7", rd, 32'd0, "error data");
          check("R7", 32'(lat), 32'd0, "error latency");
          @(negedge clk);
          check("R7", {30'd0, resp_valid, resp_err}, 32'd0, "error one cycle");
          check("R7", 32'((n_rd - r0) + (n_wr - w0)), 32'd0, "no memory traffic");
        end
    end
    for (int w = 0; w < NWORDS; w++) begin
      access(1'b0, SBASE + 4*w, 2'd2, 32'd0, rd, e, lat);
      check("R7", rd, ref_word(w), "memory intact after errors");
    end

    finish_run();
  end
endmodule